// File: doc/BRIEF.md
# BAR Window Decoder

This block keeps one address window for each of six base address registers of a PCI function and resolves incoming bus addresses against those windows. It watches BAR write events coming from the configuration header. Each event names the BAR slot, says whether that BAR is an I/O or a memory BAR, and carries the 32-bit value software wrote. From an accepted write the block derives an absolute window base. It strips the type bits from the value and adds a fixed host offset, one offset for I/O windows and another for memory windows. The window is turned on only once a value that carries a real address has been written.

Every window has a power-of-two span, set per slot by a parameter. For each lookup the block returns, one clock later, a registered hit flag, the index of the matching BAR and the byte offset of the address inside that window. Overlapping windows are resolved in favour of the lowest BAR index. The configuration register storage and the data path for the access itself live elsewhere.

Top module: `bar_window_decoder`

## Requirements
- R1: A synchronous active-high reset disables every window and clears the outputs (hit low, index 0, offset 0). After reset no address hits until a window is programmed.
- R2: An I/O write (wr_io=1) to slot i sets the base of window i to (value with bit 0 cleared) + IO_OFS and enables it. A value of exactly 0x0000_0001 leaves window i unchanged.
- R3: A memory write (wr_io=0) to slot i sets the base to (value with bits 1:0 cleared) + MEM_OFS and enables it, but only when bits 31:2 of the value are not all zero. Otherwise window i is left unchanged.
- R4: A write of 0xFFFF_FFFF (a size probe) to any slot leaves that slot's window, enabled state and base unchanged.
- R5: Rewriting an enabled slot moves its window. The old range no longer hits, the new one does, and a window once enabled stays enabled until reset.
- R6: An address hits window i when base_i <= addr < base_i + 2^SIZE_LOG2[i], where slot i's exponent is the 6-bit field at bits [6i+5:6i] of SIZE_LOG2. On a hit, hit_off is addr - base_i and hit_idx is i.
- R7: When several enabled windows contain the address, hit_idx reports the lowest index.
- R8: Outputs are registered. A lookup presented in one cycle is reported after the next rising edge. A lookup in the same cycle as a BAR write is resolved against the windows as they stood before that write.
- R9: When lk_en is low, or when no window contains the address, the next outputs are hit=0, hit_idx=0 and hit_off=0.
- R10: A write whose slot index is 6 or 7 changes no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | A BAR write event is present this cycle |
| wr_idx | input | 3 | BAR slot the write targets |
| wr_io | input | 1 | 1 = the targeted BAR is an I/O BAR, 0 = memory BAR |
| wr_value | input | 32 | Value written to the BAR |
| lk_en | input | 1 | A lookup address is present this cycle |
| lk_addr | input | ADDR_W | Bus address to decode |
| hit | output | 1 | Registered: the last lookup fell in an enabled window |
| hit_idx | output | 3 | Registered: index of the winning BAR |
| hit_off | output | ADDR_W | Registered: offset of the address inside the winning window |

## Verification
A BAR write and a lookup can arrive in the same cycle. When the lookup targets either the slot's old range or its new one, the decoder must resolve it against the window as it stood before the write. The bench provokes this by moving BAR0 while looking up its old base, and by enabling BAR5 while looking up its future base. A behavioural model resolves each lookup before it applies that cycle's write, and its answer is compared with the outputs after every edge. The following cycle then checks that the moved window is in force.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int BAR_W  = 32;  // width of a BAR value as written by software
    localparam int IDX_W  = 3;   // width of a BAR slot index
    localparam int LOG2_W = 6;   // width of one window-size exponent field

    typedef enum logic {
        WIN_MEM = 1'b0,
        WIN_IO  = 1'b1
    } win_kind_e;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        win_kind_e         kind;
        logic [BAR_W-1:0]  value;
    } bar_wr_t;

    // all-ones write: a size probe that must not move a window
    function automatic logic is_probe(input logic [BAR_W-1:0] v);
        return &v;
    endfunction

    // does the written value carry a usable address for its window kind
    function automatic logic carries_addr(input win_kind_e k, input logic [BAR_W-1:0] v);
        if (k == WIN_IO)
            return v != BAR_W'(1);
        else
            return |v[BAR_W-1:2];
    endfunction

    // remove the type bits from the written value
    function automatic logic [BAR_W-1:0] strip_type(input win_kind_e k, input logic [BAR_W-1:0] v);
        if (k == WIN_IO)
            return {v[BAR_W-1:1], 1'b0};
        else
            return {v[BAR_W-1:2], 2'b00};
    endfunction

endpackage

// File: rtl/bwd_window.sv
module bwd_window
    import bwd_pkg::*;
#(
    parameter int              ADDR_W    = 40,
    parameter int              SLOT      = 0,
    parameter int              SIZE_LOG2 = 8,
    parameter logic [ADDR_W-1:0] IO_OFS  = '0,
    parameter logic [ADDR_W-1:0] MEM_OFS = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  bar_wr_t           wr,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              match,
    output logic [ADDR_W-1:0] offset
);

    localparam logic [ADDR_W:0]  SPAN    = (ADDR_W+1)'(1) << SIZE_LOG2;
    localparam logic [IDX_W-1:0] MY_SLOT = IDX_W'(SLOT);

    logic              en_q;
    logic [ADDR_W-1:0] base_q;
    logic              mine;
    logic              take;
    logic [ADDR_W-1:0] base_next;
    logic              above_lo;
    logic              below_hi;

    assign mine      = wr.valid && (wr.idx == MY_SLOT);
    assign take      = mine && !is_probe(wr.value) && carries_addr(wr.kind, wr.value);
    assign base_next = ADDR_W'(strip_type(wr.kind, wr.value))
                     + ((wr.kind == WIN_IO) ? IO_OFS : MEM_OFS);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            base_q <= '0;
        end else if (take) begin
            en_q   <= 1'b1;
            base_q <= base_next;
        end
    end

    assign above_lo = lk_addr >= base_q;
    assign below_hi = {1'b0, lk_addr} < ({1'b0, base_q} + SPAN);
    assign match    = en_q && above_lo && below_hi;
    assign offset   = lk_addr - base_q;

    // R1: reset leaves the window off with a zero base
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!en_q && base_q == '0));

    // R5: once on, a window stays on until reset
    a_r5_window_stays_enabled: assert property (@(posedge clk) disable iff (rst)
        en_q |=> en_q);

    // R4: a size probe moves nothing
    a_r4_probe_keeps_window: assert property (@(posedge clk) disable iff (rst)
        (mine && is_probe(wr.value)) |=> ($stable(en_q) && $stable(base_q)));

    // R3 (and R2): a value without an address leaves the window as it was
    a_r3_no_address_keeps_window: assert property (@(posedge clk) disable iff (rst)
        (mine && !carries_addr(wr.kind, wr.value)) |=> ($stable(en_q) && $stable(base_q)));

endmodule

// File: rtl/bwd_pick.sv
module bwd_pick
    import bwd_pkg::*;
#(
    parameter int N      = 6,
    parameter int ADDR_W = 40
) (
    input  logic [N-1:0]             match,
    input  logic [N-1:0][ADDR_W-1:0] offs,
    output logic                     any,
    output logic [IDX_W-1:0]         idx,
    output logic [ADDR_W-1:0]        off
);

    // scan from the top so the lowest matching index is written last
    always_comb begin
        any = 1'b0;
        idx = '0;
        off = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
                off = offs[i];
            end
        end
    end

endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
    import bwd_pkg::*;
#(
    parameter int                           NUM_BARS  = 6,
    parameter int                           ADDR_W    = 40,
    parameter logic [NUM_BARS*LOG2_W-1:0]   SIZE_LOG2 = {6'd10, 6'd20, 6'd4, 6'd16, 6'd12, 6'd8},
    parameter logic [ADDR_W-1:0]            IO_OFS    = 40'h10_0000_0000,
    parameter logic [ADDR_W-1:0]            MEM_OFS   = 40'h20_0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_idx,
    input  logic              wr_io,
    input  logic [31:0]       wr_value,
    input  logic              lk_en,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic [2:0]        hit_idx,
    output logic [ADDR_W-1:0] hit_off
);

    bar_wr_t                          wr_cmd;
    logic [NUM_BARS-1:0]              match_v;
    logic [NUM_BARS-1:0][ADDR_W-1:0]  offs_v;
    logic                             any_hit;
    logic [IDX_W-1:0]                 win_idx;
    logic [ADDR_W-1:0]                win_off;

    assign wr_cmd = '{valid: wr_en, idx: wr_idx, kind: win_kind_e'(wr_io), value: wr_value};

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_win
        bwd_window #(
            .ADDR_W    (ADDR_W),
            .SLOT      (g),
            .SIZE_LOG2 (int'(SIZE_LOG2[g*LOG2_W +: LOG2_W])),
            .IO_OFS    (IO_OFS),
            .MEM_OFS   (MEM_OFS)
        ) u_win (
            .clk     (clk),
            .rst     (rst),
            .wr      (wr_cmd),
            .lk_addr (lk_addr),
            .match   (match_v[g]),
            .offset  (offs_v[g])
        );
    end

    bwd_pick #(
        .N      (NUM_BARS),
        .ADDR_W (ADDR_W)
    ) u_pick (
        .match (match_v),
        .offs  (offs_v),
        .any   (any_hit),
        .idx   (win_idx),
        .off   (win_off)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hit     <= 1'b0;
            hit_idx <= '0;
            hit_off <= '0;
        end else if (lk_en && any_hit) begin
            hit     <= 1'b1;
            hit_idx <= win_idx;
            hit_off <= win_off;
        end else begin
            hit     <= 1'b0;
            hit_idx <= '0;
            hit_off <= '0;
        end
    end

    function automatic logic [ADDR_W:0] span_of(input logic [IDX_W-1:0] i);
        return (ADDR_W+1)'(1) << SIZE_LOG2[int'(i)*LOG2_W +: LOG2_W];
    endfunction

    function automatic logic [NUM_BARS-1:0] below_mask(input logic [IDX_W-1:0] i);
        return NUM_BARS'((1 << i) - 1);
    endfunction

    // R9: a hit is reported only for a lookup that was presented
    a_r9_hit_needs_lookup: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(lk_en));

    // R10: a reported index always names an existing BAR
    a_r10_index_in_range: assert property (@(posedge clk) disable iff (rst)
        hit |-> (int'(hit_idx) < NUM_BARS));

    // R6: the reported offset lies inside the winning window
    a_r6_offset_inside_window: assert property (@(posedge clk) disable iff (rst)
        (hit && int'(hit_idx) < NUM_BARS) |-> ({1'b0, hit_off} < span_of(hit_idx)));

    // R7: no lower-indexed window matched the lookup that hit
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (rst)
        hit |-> (($past(match_v) & below_mask(hit_idx)) == '0));

endmodule

// File: tb/bar_window_decoder_tb_top.sv
module bar_window_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 6;
    localparam int AW         = 40;
    localparam logic [AW-1:0] IO  = 40'h10_0000_0000;
    localparam logic [AW-1:0] MEM = 40'h20_0000_0000;
    localparam int SZ [NB] = '{8, 12, 16, 4, 20, 10};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_idx = '0;
    logic          wr_io = 1'b0;
    logic [31:0]   wr_value = '0;
    logic          lk_en = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          hit;
    logic [2:0]    hit_idx;
    logic [AW-1:0] hit_off;

    int vectors = 0;
    int miscompares = 0;

    // behavioural model state
    bit            m_en   [NB];
    logic [AW:0]   m_base [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    bar_window_decoder dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_io(wr_io), .wr_value(wr_value),
        .lk_en(lk_en), .lk_addr(lk_addr),
        .hit(hit), .hit_idx(hit_idx), .hit_off(hit_off)
    );

    task automatic compare(input string tag, input bit eh, input int ei, input logic [AW-1:0] eo);
        vectors++;
        if (hit !== eh || int'(hit_idx) != ei || hit_off !== eo) begin
            miscompares++;
            $display("FAIL %s: actual hit=%0b idx=%0d off=%0h expected hit=%0b idx=%0d off=%0h",
                     tag, hit, hit_idx, hit_off, eh, ei, eo);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NB; i++) begin
            m_en[i]   = 1'b0;
            m_base[i] = '0;
        end
    endtask

    // one clock: drive, predict from pre-write model, update model, compare after edge
    task automatic step(input bit we, input int wi, input bit wio, input logic [31:0] wv,
                        input bit le, input logic [AW-1:0] la, input string tag);
        bit            eh = 1'b0;
        int            ei = 0;
        logic [AW-1:0] eo = '0;
        @(negedge clk);
        wr_en = we; wr_idx = 3'(wi); wr_io = wio; wr_value = wv;
        lk_en = le; lk_addr = la;
        if (le) begin
            for (int i = NB - 1; i >= 0; i--) begin
                if (m_en[i] && {1'b0, la} >= m_base[i] &&
                    {1'b0, la} < m_base[i] + ((AW+1)'(1) << SZ[i])) begin
                    eh = 1'b1; ei = i; eo = la - m_base[i][AW-1:0];
                end
            end
        end
        if (we && wi < NB && wv != 32'hFFFF_FFFF) begin
            if (wio) begin
                if (wv != 32'h1) begin
                    m_en[wi]   = 1'b1;
                    m_base[wi] = {1'b0, IO + AW'(wv & ~32'h1)};
                end
            end else if (wv[31:2] != 0) begin
                m_en[wi]   = 1'b1;
                m_base[wi] = {1'b0, MEM + AW'(wv & ~32'h3)};
            end
        end
        @(posedge clk);
        #1;
        compare(tag, eh, ei, eo);
    endtask

    task automatic look(input logic [AW-1:0] la, input string tag);
        step(1'b0, 0, 1'b0, 32'h0, 1'b1, la, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] r = 32'h1234_5678;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset outputs", 1'b0, 0, '0);
        @(negedge clk);
        rst = 1'b0;
        look(MEM, "R1 no window after reset");
        look(IO,  "R1 no window after reset");
        look('0,  "R1 no window after reset");

        // R8: write and lookup in the same cycle use the old window
        step(1'b1, 0, 1'b0, 32'h0000_1080, 1'b1, MEM + 40'h1080, "R8 same-cycle write");
        look(MEM + 40'h1080, "R3 memory base");
        look(MEM + 40'h117F, "R6 top byte");
        look(MEM + 40'h1180, "R6 one past top");
        look(MEM + 40'h107F, "R6 one below base");

        // R7: overlap of BAR0 inside BAR1
        step(1'b1, 1, 1'b0, 32'h0000_1000, 1'b0, '0, "R9 idle lookup");
        look(MEM + 40'h1100, "R7 lowest index wins");
        look(MEM + 40'h1000, "R6 BAR1 base");
        look(MEM + 40'h1FFF, "R6 BAR1 top");

        // R2: I/O windows
        step(1'b1, 3, 1'b1, 32'h0000_0201, 1'b0, '0, "R9 idle lookup");
        look(IO + 40'h200, "R2 io base");
        look(IO + 40'h20F, "R2 io top");
        look(IO + 40'h210, "R2 io past top");
        step(1'b1, 4, 1'b1, 32'h0000_0001, 1'b0, '0, "R9 idle lookup");
        look(IO, "R2 value one does not enable");
        step(1'b1, 3, 1'b1, 32'h0000_0001, 1'b0, '0, "R9 idle lookup");
        look(IO + 40'h200, "R2 value one keeps window");

        // R3: memory write without address bits
        step(1'b1, 2, 1'b0, 32'h0000_0003, 1'b0, '0, "R9 idle lookup");
        look(MEM, "R3 no address bits");

        // R4: size probe
        step(1'b1, 0, 1'b0, 32'hFFFF_FFFF, 1'b0, '0, "R9 idle lookup");
        look(MEM + 40'h1080, "R4 probe keeps window");
        look(MEM + 40'hFFFF_FFF0, "R4 probe makes no window");

        // R10: out-of-range slot
        step(1'b1, 6, 1'b0, 32'h0000_5000, 1'b0, '0, "R9 idle lookup");
        step(1'b1, 7, 1'b1, 32'h0000_0400, 1'b0, '0, "R9 idle lookup");
        look(MEM + 40'h5000, "R10 slot 6 ignored");
        look(IO + 40'h400, "R10 slot 7 ignored");
        look(MEM + 40'h1080, "R10 BAR0 unchanged");

        // R5 / R8: move BAR0 while looking up its old base
        step(1'b1, 0, 1'b0, 32'h0000_8000, 1'b1, MEM + 40'h1090, "R8 old base same cycle");
        look(MEM + 40'h1090, "R5 old range now BAR1");
        look(MEM + 40'h8000, "R5 new base");
        look(MEM + 40'h80FF, "R5 new top");

        // R9: lookup disabled inside a window
        step(1'b0, 0, 1'b0, 32'h0, 1'b0, MEM + 40'h8000, "R9 lookup disabled");

        // R8: enable BAR5 while looking up its future base
        step(1'b1, 5, 1'b0, 32'h0004_0000, 1'b1, MEM + 40'h4_0000, "R8 before enable");
        look(MEM + 40'h4_0000, "R8 after enable");
        look(MEM + 40'h4_03FF, "R6 BAR5 top");

        // mixed traffic
        for (int n = 0; n < 300; n++) begin
            logic [AW-1:0] pick;
            logic [31:0]   v;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            case (r[1:0])
                2'd0: pick = MEM + 40'h1000;
                2'd1: pick = MEM + 40'h8000;
                2'd2: pick = IO + 40'h200;
                default: pick = MEM + 40'h4_0000;
            endcase
            case (r[9:8])
                2'd0: v = {12'h0, r[27:10], 2'b00};
                2'd1: v = 32'h1;
                2'd2: v = 32'hFFFF_FFFF;
                default: v = 32'h3;
            endcase
            step(r[7:5] == 3'd0, int'(r[30:28]), r[31], v, r[4] | r[2],
                 pick + AW'(r[21:10]) - 40'h80, "R6 mixed traffic");
        end

        // R1: reset in mid-run clears every window
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        @(posedge clk);
        #1;
        compare("R1 reset mid-run", 1'b0, 0, '0);
        @(negedge clk);
        rst = 1'b0;
        look(MEM + 40'h8000, "R1 window cleared");
        look(IO + 40'h200, "R1 window cleared");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule